// File: doc/BRIEF.md
# SD card clock divider programmer

This block works out the divider setting for an SD card clock and applies it. The setting is found for a fixed source clock, 200 MHz by default. When a start pulse arrives with a nonzero target frequency, two searches run side by side, one step per clock:

- a power-of-two prescaler search;
- a linear divisor search.

When neither search can step any further, the block packs both results into the clock field of a control word. It then changes the clock in a safe order:

1. It drops the card clock enable.
2. It writes the new field.
3. It waits a programmable number of settle cycles.
4. It raises the peripheral and card clock enables together with a one-cycle done pulse.

A host or boot sequencer uses it to change the card clock, for example from the slow identification rate to the full data rate. It pulses `start_i`, holds the rest of the control word on `ctrl_i`, and waits for `done_o`. The counter that actually divides the clock sits outside this block and takes `clk_field_o` and the enables.

Top module: `sdclk_div_prog`

## Requirements
- R1: After reset, `clk_field_o` and `ctrl_o` are zero, and `per_clk_en_o`, `card_clk_en_o` and `done_o` are low.
- R2: The prescaler search rule:
  - The prescaler starts at 1.
  - It doubles while SRC/(16*prescaler), in integer division, exceeds the target and the prescaler is below 256.
  - Bits [15:8] of `clk_field_o` hold prescaler/2, so a prescaler of 1 gives 0.
- R3: The divisor search rule:
  - The divisor starts at 1.
  - It increments while SRC/divisor, in integer division, exceeds the target and the divisor is below 16. The test uses SRC alone, not the prescaled clock.
  - Bits [7:4] of `clk_field_o` hold divisor-1.
- R4: Bits [3:0] of `clk_field_o` are zero. `ctrl_o` equals `ctrl_i` with bits [15:4] replaced by the matching bits of the field, with `ctrl_i` taken in the cycle the field is written.
- R5: `card_clk_en_o` goes low one cycle before `clk_field_o` and `ctrl_o` change. It is still low when they change.
- R6: Once the field is written, `card_clk_en_o` stays low for SETTLE_CYCLES cycles. Then `per_clk_en_o` and `card_clk_en_o` are both high.
- R7: `done_o` is high for exactly one cycle, in the same cycle the enables come back. It is high after clock edge 4+max(Np,Nd)+SETTLE_CYCLES, counting the edge that accepts the start as edge 1. Np is the number of prescaler doublings and Nd is the number of divisor increments.
- R8: A start pulse that arrives while an update is in progress has no effect on the field, the control word or the done timing.
- R9: A start pulse with a zero target is ignored: no update runs and no done pulse follows. The target is latched at start, so later changes on `target_hz_i` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request an update (taken only when idle) |
| target_hz_i | input | TGT_W | Requested card clock in Hz |
| ctrl_i | input | CTRL_W | Current control word; bits outside the clock field pass through |
| ctrl_o | output | CTRL_W | Control word with the new clock field merged in |
| clk_field_o | output | FIELD_W | Packed divider field |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| card_clk_en_o | output | 1 | Card clock enable |
| done_o | output | 1 | One-cycle pulse when the update completes |

## Verification
Each output has a fixed due edge, which depends only on the target and SETTLE_CYCLES. The bench works out the search step counts Np and Nd from the target, and from them the edges at which:

- the card enable falls (edge max+3);
- the field and control word change (edge max+4);
- done and the enables rise (edge max+4+SETTLE_CYCLES).

The bench drives inputs and samples outputs on falling edges. It counts exactly that many edges from the start pulse, checks the cycle before each change as well as the change itself, and checks one cycle after done that the pulse has ended. Ignored starts are checked by confirming that the due times and results are unchanged, and that no extra done pulse appears in the cycles that follow.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_GATE,
    ST_APPLY,
    ST_SETTLE
  } sdclk_st_e;
endpackage

// File: rtl/sdclk_pre_search.sv
module sdclk_pre_search #(
  parameter longint unsigned SRC_HZ    = 200_000_000,
  parameter int              TGT_W     = 32,
  parameter int              PRE_STEPS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 step_en_i,
  input  logic [TGT_W-1:0]     target_i,
  output logic                 go_o,
  output logic [PRE_STEPS-1:0] half_o
);
  localparam int                EXP_W   = $clog2(PRE_STEPS + 1);
  localparam logic [EXP_W-1:0]  EXP_MAX = EXP_W'(PRE_STEPS);
  localparam logic [63:0]       SRC_16  = 64'(SRC_HZ) >> 4;

  logic [EXP_W-1:0] exp_q;
  logic [TGT_W-1:0] tgt_q;
  logic [63:0]      scaled;
  logic [PRE_STEPS:0] pre;

  // exponent form of the prescaler: pre = 2**exp_q
  assign scaled = SRC_16 >> exp_q;
  assign go_o   = (exp_q < EXP_MAX) && (scaled > 64'(tgt_q));
  assign pre    = (PRE_STEPS+1)'(1) << exp_q;
  assign half_o = pre[PRE_STEPS:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      tgt_q <= '0;
    end else if (load_i) begin
      exp_q <= '0;
      tgt_q <= target_i;
    end else if (step_en_i && go_o) begin
      exp_q <= exp_q + EXP_W'(1);
    end
  end

  // R2
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q <= EXP_MAX);
endmodule

// File: rtl/sdclk_div_search.sv
module sdclk_div_search #(
  parameter longint unsigned SRC_HZ  = 200_000_000,
  parameter int              TGT_W   = 32,
  parameter int              DIV_MAX = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic                         step_en_i,
  input  logic [TGT_W-1:0]             target_i,
  output logic                         go_o,
  output logic [$clog2(DIV_MAX)-1:0]   div_m1_o
);
  localparam int               DIV_W   = $clog2(DIV_MAX + 1);
  localparam int               DIV_FW  = $clog2(DIV_MAX);
  localparam int               ACC_W   = TGT_W + 1 + DIV_W;
  localparam logic [DIV_W-1:0] DIV_LIM = DIV_W'(DIV_MAX);
  localparam logic [ACC_W-1:0] SRC_A   = ACC_W'(SRC_HZ);

  logic [DIV_W-1:0] div_q;
  logic [TGT_W:0]   step_q;
  logic [ACC_W-1:0] acc_q;
  logic [DIV_W-1:0] div_m1;

  // floor(SRC/div) > t  <=>  SRC >= (t+1)*div ; acc_q tracks (t+1)*div
  assign go_o     = (div_q < DIV_LIM) && (SRC_A >= acc_q);
  assign div_m1   = div_q - DIV_W'(1);
  assign div_m1_o = div_m1[DIV_FW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_W'(1);
      step_q <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      div_q  <= DIV_W'(1);
      step_q <= {1'b0, target_i} + (TGT_W+1)'(1);
      acc_q  <= ACC_W'({1'b0, target_i}) + ACC_W'(1);
    end else if (step_en_i && go_o) begin
      div_q  <= div_q + DIV_W'(1);
      acc_q  <= acc_q + ACC_W'(step_q);
    end
  end

  // R3
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q >= DIV_W'(1)) && (div_q <= DIV_LIM));
endmodule

// File: rtl/sdclk_settle_timer.sv
module sdclk_settle_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic expire_o
);
  localparam int               CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD  = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q - ONE;
      if (expire_o) run_q <= 1'b0;
    end
  end

  // R6
  settle_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/sdclk_div_prog.sv
module sdclk_div_prog
  import sdclk_pkg::*;
#(
  parameter longint unsigned SRC_HZ        = 200_000_000,
  parameter int              TGT_W         = 32,
  parameter int              PRE_STEPS     = 8,
  parameter int              DIV_MAX       = 16,
  parameter int              SETTLE_CYCLES = 1000,
  parameter int              CTRL_W        = 32,
  parameter int              FIELD_W       = PRE_STEPS + $clog2(DIV_MAX) + 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [TGT_W-1:0]   target_hz_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [FIELD_W-1:0] clk_field_o,
  output logic               per_clk_en_o,
  output logic               card_clk_en_o,
  output logic               done_o
);
  localparam int                DIV_FW   = $clog2(DIV_MAX);
  localparam logic [CTRL_W-1:0] CLK_MASK = CTRL_W'({{(FIELD_W-4){1'b1}}, 4'b0000});

  sdclk_st_e st_q;
  logic [PRE_STEPS-1:0] pre_half;
  logic [DIV_FW-1:0]    div_m1;
  logic [FIELD_W-1:0]   field_nxt;
  logic                 pre_go, div_go, accept, searching, settle_done;

  assign accept    = (st_q == ST_IDLE) && start_i && (target_hz_i != '0);
  assign searching = (st_q == ST_SEARCH);
  assign field_nxt = {pre_half, div_m1, 4'b0000};

  sdclk_pre_search #(
    .SRC_HZ(SRC_HZ), .TGT_W(TGT_W), .PRE_STEPS(PRE_STEPS)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .step_en_i(searching),
    .target_i(target_hz_i), .go_o(pre_go), .half_o(pre_half)
  );

  sdclk_div_search #(
    .SRC_HZ(SRC_HZ), .TGT_W(TGT_W), .DIV_MAX(DIV_MAX)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .step_en_i(searching),
    .target_i(target_hz_i), .go_o(div_go), .div_m1_o(div_m1)
  );

  sdclk_settle_timer #(
    .CYCLES(SETTLE_CYCLES)
  ) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(st_q == ST_APPLY), .expire_o(settle_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      clk_field_o   <= '0;
      ctrl_o        <= '0;
      per_clk_en_o  <= 1'b0;
      card_clk_en_o <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE:   if (accept) st_q <= ST_SEARCH;
        ST_SEARCH: if (!pre_go && !div_go) st_q <= ST_GATE;
        ST_GATE: begin
          card_clk_en_o <= 1'b0;
          st_q          <= ST_APPLY;
        end
        ST_APPLY: begin
          clk_field_o <= field_nxt;
          ctrl_o      <= (ctrl_i & ~CLK_MASK) | CTRL_W'(field_nxt);
          st_q        <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done) begin
          per_clk_en_o  <= 1'b1;
          card_clk_en_o <= 1'b1;
          done_o        <= 1'b1;
          st_q          <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  card_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_field_o) |-> !card_clk_en_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (per_clk_en_o && card_clk_en_o));

  // R9
  zero_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && start_i && (target_hz_i == '0)) |=> (st_q == ST_IDLE));
endmodule

// File: tb/sdclk_div_prog_test.sv
module sdclk_div_prog_test;
  localparam longint SRC    = 200_000_000;
  localparam int     SETTLE = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] target_hz_i = '0;
  logic [31:0] ctrl_i = '0;
  logic [31:0] ctrl_o;
  logic [15:0] clk_field_o;
  logic        per_clk_en_o, card_clk_en_o, done_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_field = '0;
  logic [31:0] last_ctrl  = '0;
  logic        prev_card  = 1'b0;

  always #4 clk_i = ~clk_i;

  sdclk_div_prog #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .target_hz_i(target_hz_i),
    .ctrl_i(ctrl_i), .ctrl_o(ctrl_o), .clk_field_o(clk_field_o),
    .per_clk_en_o(per_clk_en_o), .card_clk_en_o(card_clk_en_o), .done_o(done_o)
  );

  function automatic int exp_np(longint t);
    longint p = 1;
    int n = 0;
    while ((SRC / (16 * p)) > t && p < 256) begin p = p * 2; n++; end
    return n;
  endfunction

  function automatic int exp_nd(longint t);
    longint d = 1;
    while ((SRC / d) > t && d < 16) d++;
    return int'(d - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_update(input logic [31:0] t, input logic [31:0] c, input bit poke);
    int np, nd, m;
    logic [15:0] ef;
    logic [31:0] ec;
    np = exp_np(longint'(t));
    nd = exp_nd(longint'(t));
    m  = (np > nd) ? np : nd;
    ef = 16'(((1 << np) >> 1) << 8) | 16'(nd << 4);
    ec = (c & ~32'h0000_FFF0) | {16'h0, ef};
    @(negedge clk_i);
    start_i = 1'b1; target_hz_i = t; ctrl_i = c;
    wait_n(1);                           // edge 1 accepted
    start_i = 1'b0; target_hz_i = ~t;    // R9 target must be latched
    wait_n(m + 1);                       // after edge m+2
    chk(card_clk_en_o == prev_card, "R5 card enable before gate", card_clk_en_o, prev_card);
    wait_n(1);                           // m+3
    chk(card_clk_en_o == 1'b0 && clk_field_o == last_field, "R5 gated before write",
        {card_clk_en_o, clk_field_o}, {1'b0, last_field});
    wait_n(1);                           // m+4
    chk(clk_field_o[15:8] == ef[15:8], "R2 prescaler field", clk_field_o[15:8], ef[15:8]);
    chk(clk_field_o[7:4] == ef[7:4], "R3 divisor field", clk_field_o[7:4], ef[7:4]);
    chk(clk_field_o[3:0] == 4'h0 && ctrl_o == ec, "R4 control word merge", ctrl_o, ec);
    if (poke) begin
      wait_n(1);
      start_i = 1'b1; target_hz_i = 32'd7;  // R8 start while busy
      wait_n(1);
      start_i = 1'b0;
      wait_n(SETTLE - 3);
    end else begin
      wait_n(SETTLE - 1);
    end
    chk(done_o == 1'b0 && card_clk_en_o == 1'b0, "R6 still settling",
        {done_o, card_clk_en_o}, 2'b00);
    wait_n(1);                           // m+4+SETTLE
    chk(done_o && per_clk_en_o && card_clk_en_o, "R7 done with enables",
        {done_o, per_clk_en_o, card_clk_en_o}, 3'b111);
    wait_n(1);
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    if (poke) begin
      bit saw = 1'b0;
      for (int i = 0; i < 30; i++) begin
        wait_n(1);
        if (done_o) saw = 1'b1;
      end
      chk(!saw && clk_field_o == ef && ctrl_o == ec, "R8 busy start ignored",
          {saw, clk_field_o}, {1'b0, ef});
    end
    last_field = ef;
    last_ctrl  = ec;
    prev_card  = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5D1C));
    wait_n(3);
    chk(clk_field_o == '0 && ctrl_o == '0 && !per_clk_en_o && !card_clk_en_o && !done_o,
        "R1 reset state", {clk_field_o, per_clk_en_o, card_clk_en_o, done_o}, 0);
    rst_ni = 1'b1;
    wait_n(2);
    chk(clk_field_o == '0 && !done_o, "R1 after release", clk_field_o, 0);

    do_update(32'd400_000,     32'hFFFF_FFFF, 1'b0);
    do_update(32'd1,           32'h1234_5678, 1'b1);
    do_update(32'd12_500_000,  32'hA5A5_A5A5, 1'b0);
    do_update(32'd12_499_999,  32'h0000_000F, 1'b0);
    do_update(32'd200_000_000, 32'h8000_0001, 1'b0);
    do_update(32'd300_000_000, 32'hDEAD_BEEF, 1'b1);
    do_update(32'd25_000_000,  32'h0F0F_0F0F, 1'b0);
    do_update(32'd50_000_000,  32'h0000_0000, 1'b0);

    // R9 zero target
    begin
      bit saw = 1'b0;
      @(negedge clk_i);
      start_i = 1'b1; target_hz_i = '0;
      wait_n(1);
      start_i = 1'b0;
      for (int i = 0; i < 40; i++) begin
        wait_n(1);
        if (done_o) saw = 1'b1;
      end
      chk(!saw && clk_field_o == last_field && card_clk_en_o == prev_card && ctrl_o == last_ctrl,
          "R9 zero target ignored", {saw, clk_field_o}, {1'b0, last_field});
    end

    for (int k = 0; k < 16; k++) begin
      logic [31:0] t;
      case (k % 3)
        0: t = $urandom_range(1, 1000);
        1: t = $urandom_range(1, 2_000_000);
        default: t = $urandom_range(1, 300_000_000);
      endcase
      do_update(t, $urandom, (k % 4) == 3);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule